// File: doc/BRIEF.md
# Fractional Clock Divider with Synchronized Enable

This block derives a slower clock from a source clock by a divisor held as a 32-bit fixed-point word. The upper 24 bits are the integer part and the lower 8 bits are the fraction. The word to load is the source frequency times 256 divided by the wanted output frequency. Each output period lasts either the integer part or one more source cycle. An 8-bit phase accumulator picks which, so that the mean period matches the divisor exactly over every window of 256 output periods.

The enable input may come from any domain. A short synchronizer first brings it into the source domain. It then passes through a pipeline that advances only at output period boundaries. Starting and stopping therefore always happen at the start of a period, and no high phase is ever cut short. The divisor can be changed while the output runs, and a new value takes effect at the next period start. The output can never be faster than the input: any word below 1.0 is raised to 1.0. At exactly 1.0 the source clock is passed straight through.

Top module: `frac_clk_div`

## Requirements
- R1: Over any 256 consecutive output periods with a steady divisor word W of at least 2.0 (W >= 0x200), the output periods together span exactly W source cycles, W read as an integer.
- R2: A word below 0x100 behaves exactly like 0x100 (pass-through). A word with integer part 1 and a non-zero fraction (0x101 to 0x1FF) behaves like 0x200.
- R3: With an effective divisor of integer part N >= 2 (bits 31:8) and fraction F (bits 7:0), every output period lasts N or N+1 source cycles, and exactly N when F is zero. Each period starts with a rising output edge.
- R4: Outside pass-through, the output high time of a period of L source cycles is floor(L/2) source cycles, followed by the low time.
- R5: With an effective divisor of exactly 0x100 and enable active, the output follows the source clock: high in the source-high half cycle and low in the source-low half.
- R6: A divisor word changed in the middle of a period leaves that period at its old length. All following periods use the new word.
- R7: After enable falls, the output rises at most 3 more times, each with a full high phase, and then stays low.
- R8: After enable rises, the first output edge comes within two source cycles plus three output periods, and the first period has full length.
- R9: After reset, with enable low, the output stays low and shows no edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_word | input | 32 | Divisor, 24 integer bits above 8 fraction bits |
| enable | input | 1 | Output enable, may be asynchronous |
| clk_out | output | 1 | Divided clock |

## Verification
The bench sweeps the integer divisors 2 to 12 and measures both the period and the high time. An off-by-one in the period counter or in the halving would show up there as a period one cycle long or short, or as a stretched high phase. Several fractions, including the extremes 0x01 and 0xFF, are run over 256 full periods and the total is compared with the word itself. A carry that was dropped, or added twice, would move that total by the fraction. Other runs check the clamping of words below 1.0 and below 2.0, and a divisor change in the middle of a period, which would give one hybrid period if applied at once. The last runs stop and restart the enable: a gate applied directly to the output would clip a high pulse or start part way through a period.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  // Classification of a raw divisor word before it is applied.
  typedef enum logic [1:0] {
    DCLS_UNDER,   // below 1.0, raised to 1.0
    DCLS_UNITY,   // exactly 1.0, pass-through
    DCLS_SUB2,    // between 1.0 and 2.0, raised to 2.0
    DCLS_NORMAL   // 2.0 or more, used as written
  } div_class_e;

endpackage

// File: rtl/fcd_en_sync.sv
module fcd_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], d};
    end
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/fcd_div_calc.sv
module fcd_div_calc
  import fcd_pkg::*;
#(
  parameter int unsigned INT_W  = 24,
  parameter int unsigned FRAC_W = 8
) (
  input  logic [INT_W+FRAC_W-1:0] div_word,
  input  logic [FRAC_W-1:0]       acc_q,
  output logic                    pass,
  output logic [INT_W:0]          len,
  output logic [INT_W-1:0]        high,
  output logic [FRAC_W-1:0]       acc_next
);

  localparam int unsigned DIV_W = INT_W + FRAC_W;
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1) << FRAC_W;
  localparam logic [DIV_W-1:0] TWO = DIV_W'(2) << FRAC_W;

  function automatic div_class_e classify(input logic [DIV_W-1:0] w);
    if (w < ONE)       return DCLS_UNDER;
    else if (w == ONE) return DCLS_UNITY;
    else if (w < TWO)  return DCLS_SUB2;
    else               return DCLS_NORMAL;
  endfunction

  function automatic logic [DIV_W-1:0] effective(input logic [DIV_W-1:0] w,
                                                 input div_class_e c);
    case (c)
      DCLS_UNDER, DCLS_UNITY: return ONE;
      DCLS_SUB2:              return TWO;
      default:                return w;
    endcase
  endfunction

  div_class_e         cls;
  logic [DIV_W-1:0]   eff;
  logic [FRAC_W:0]    sum;
  logic               carry;

  always_comb begin
    cls      = classify(div_word);
    eff      = effective(div_word, cls);
    pass     = (eff == ONE);
    sum      = {1'b0, acc_q} + {1'b0, eff[FRAC_W-1:0]};
    carry    = sum[FRAC_W];
    acc_next = sum[FRAC_W-1:0];
    len      = {1'b0, eff[DIV_W-1:FRAC_W]} + {{INT_W{1'b0}}, carry};
    high     = len[INT_W:1];
  end

endmodule

// File: rtl/fcd_period_gen.sv
module fcd_period_gen #(
  parameter int unsigned INT_W  = 24,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned PIPE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic [INT_W:0]    len_in,
  input  logic [INT_W-1:0]  high_in,
  input  logic              pass_in,
  input  logic [FRAC_W-1:0] acc_next_in,
  output logic              period_end,
  output logic [INT_W:0]    phase_q,
  output logic [INT_W:0]    len_q,
  output logic [INT_W-1:0]  high_q,
  output logic              pass_q,
  output logic [FRAC_W-1:0] acc_q,
  output logic              run_q,
  output logic              out_q
);

  logic [INT_W:0] phase_next;
  logic [PIPE-1:0] pipe_q;
  logic [PIPE-1:0] pipe_d;

  assign phase_next = phase_q + (INT_W+1)'(1);
  assign period_end = (phase_next == len_q);
  assign pipe_d     = {pipe_q[PIPE-2:0], en_req};
  assign run_q      = pipe_q[PIPE-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      len_q   <= (INT_W+1)'(1);
      high_q  <= '0;
      pass_q  <= 1'b1;
      acc_q   <= '0;
      pipe_q  <= '0;
      out_q   <= 1'b0;
    end else if (period_end) begin
      phase_q <= '0;
      len_q   <= len_in;
      high_q  <= high_in;
      pass_q  <= pass_in;
      acc_q   <= acc_next_in;
      pipe_q  <= pipe_d;
      out_q   <= pipe_d[PIPE-1] && !pass_in;
    end else begin
      phase_q <= phase_next;
      out_q   <= run_q && !pass_q && (phase_next < {1'b0, high_q});
    end
  end

endmodule

// File: rtl/fcd_pass_gate.sv
module fcd_pass_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pass_q,
  input  logic run_q,
  input  logic out_q,
  output logic clk_out
);

  logic gate_q;

  // Gate updated while the source is low so it cannot clip a high phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= pass_q && run_q;
  end

  assign clk_out = (clk & gate_q) | out_q;

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int unsigned INT_W       = 24,
  parameter int unsigned FRAC_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned EN_PIPE     = 2
) (
  input  logic                    clk_src,
  input  logic                    rst_n,
  input  logic [INT_W+FRAC_W-1:0] div_word,
  input  logic                    enable,
  output logic                    clk_out
);

  logic              en_req;
  logic              calc_pass;
  logic [INT_W:0]    calc_len;
  logic [INT_W-1:0]  calc_high;
  logic [FRAC_W-1:0] calc_acc_next;
  logic              period_end;
  logic [INT_W:0]    phase_q;
  logic [INT_W:0]    len_q;
  logic [INT_W-1:0]  high_q;
  logic              pass_q;
  logic [FRAC_W-1:0] acc_q;
  logic              run_q;
  logic              out_q;

  fcd_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_src),
    .rst_n (rst_n),
    .d     (enable),
    .q     (en_req)
  );

  fcd_div_calc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_calc (
    .div_word (div_word),
    .acc_q    (acc_q),
    .pass     (calc_pass),
    .len      (calc_len),
    .high     (calc_high),
    .acc_next (calc_acc_next)
  );

  fcd_period_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PIPE(EN_PIPE)) u_gen (
    .clk         (clk_src),
    .rst_n       (rst_n),
    .en_req      (en_req),
    .len_in      (calc_len),
    .high_in     (calc_high),
    .pass_in     (calc_pass),
    .acc_next_in (calc_acc_next),
    .period_end  (period_end),
    .phase_q     (phase_q),
    .len_q       (len_q),
    .high_q      (high_q),
    .pass_q      (pass_q),
    .acc_q       (acc_q),
    .run_q       (run_q),
    .out_q       (out_q)
  );

  fcd_pass_gate u_gate (
    .clk     (clk_src),
    .rst_n   (rst_n),
    .pass_q  (pass_q),
    .run_q   (run_q),
    .out_q   (out_q),
    .clk_out (clk_out)
  );

endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
  parameter int unsigned INT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             period_end,
  input logic [INT_W:0]   phase_q,
  input logic [INT_W:0]   len_q,
  input logic [INT_W-1:0] high_q,
  input logic             pass_q,
  input logic             run_q,
  input logic             out_q
);

  // R6: the applied period length only moves at a period boundary
  assert_len_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(period_end) |-> $stable(len_q));

  // R7: the enable state only moves at a period boundary
  assert_run_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(period_end) |-> $stable(run_q));

  // R7: no divided output without the enable state
  assert_out_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> run_q);

  // R3: rising edges only at the first cycle of a period
  assert_rise_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> (phase_q == '0));

  // R4: the divided output is high only inside the high window
  assert_high_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> (phase_q < {1'b0, high_q}));

  // R2: outside pass-through a period is never shorter than two cycles
  assert_min_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_q |-> (len_q >= (INT_W+1)'(2)));

  // R3: the phase counter stays inside the period
  assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < len_q);

endmodule

bind frac_clk_div fcd_chk u_fcd_chk (
  .clk        (clk_src),
  .rst_n      (rst_n),
  .period_end (period_end),
  .phase_q    (phase_q),
  .len_q      (len_q),
  .high_q     (high_q),
  .pass_q     (pass_q),
  .run_q      (run_q),
  .out_q      (out_q)
);

// File: tb/frac_clk_div_tb.sv
`timescale 1ns/1ps
module frac_clk_div_tb;

  logic        clk_src = 1'b0;
  logic        rst_n   = 1'b0;
  logic [31:0] div_word = 32'h300;
  logic        enable  = 1'b0;
  logic        clk_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  int cyc = 0;
  int rise_cyc = 0;
  int rise_prev = 0;
  int fall_cyc = 0;
  int rise_cnt = 0;

  frac_clk_div u_dut (
    .clk_src  (clk_src),
    .rst_n    (rst_n),
    .div_word (div_word),
    .enable   (enable),
    .clk_out  (clk_out)
  );

  always #2 clk_src = ~clk_src;

  always @(posedge clk_src) cyc = cyc + 1;
  always @(posedge clk_out) begin
    rise_prev = rise_cyc;
    rise_cyc  = cyc;
    rise_cnt  = rise_cnt + 1;
  end
  always @(negedge clk_out) fall_cyc = cyc;

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input longint act,
                             input longint lo, input longint hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic src_cycles(input int n);
    repeat (n) @(negedge clk_src);
  endtask

  task automatic wait_rises(input int n);
    repeat (n) @(posedge clk_out);
    #1;
  endtask

  task automatic set_div(input logic [31:0] w);
    @(negedge clk_src);
    div_word = w;
  endtask

  // Effective divisor in 1/256 units, from R2
  function automatic int eff_units(input logic [31:0] w);
    if (w < 32'h100) return 256;
    if (w[31:8] == 24'd1 && w[7:0] != 8'd0) return 512;
    return int'(w);
  endfunction

  // R1/R3: 256-period total and per-period bounds
  task automatic frac_run(input logic [31:0] w, input string tag);
    int e;
    int n;
    int start;
    int bad;
    e = eff_units(w);
    n = e / 256;
    bad = 0;
    set_div(w);
    wait_rises(4);
    start = rise_cyc;
    for (int k = 0; k < 256; k++) begin
      wait_rises(1);
      if ((rise_cyc - rise_prev) < n || (rise_cyc - rise_prev) > n + 1) bad++;
    end
    check({tag, " total over 256 periods"}, rise_cyc - start, e);
    check("R3 periods within N..N+1", bad, 0);
  endtask

  logic [31:0] fwords [7] = '{32'h380, 32'h301, 32'h3FF, 32'h2AB,
                              32'h7C1, 32'h1080, 32'h255};

  initial begin
    // R9: reset and idle
    src_cycles(5);
    rst_n = 1'b1;
    src_cycles(50);
    check("R9 no edges while disabled", rise_cnt, 0);
    check("R9 output low while disabled", clk_out, 0);

    // R8: start, first period full length
    begin
      int en_cyc;
      @(negedge clk_src);
      enable = 1'b1;
      en_cyc = cyc;
      wait_rises(1);
      check_range("R8 start latency", rise_cyc - en_cyc, 1, 2 + 3 * 3);
      wait_rises(1);
      check("R8 first period", rise_cyc - rise_prev, 3);
    end

    // R3/R4: integer sweep
    for (int d = 2; d <= 12; d++) begin
      set_div(32'(d) << 8);
      wait_rises(4);
      wait_rises(1);
      check("R3 integer period", rise_cyc - rise_prev, d);
      @(negedge clk_out);
      #1;
      check("R4 high time", fall_cyc - rise_cyc, d / 2);
    end

    // R1: fractional sweep
    foreach (fwords[i]) frac_run(fwords[i], "R1");

    // R2: 1.0 < word < 2.0 raised to 2.0
    frac_run(32'h180, "R2");

    // R5 and R2: pass-through at 1.0 and below
    for (int p = 0; p < 2; p++) begin
      int bad;
      bad = 0;
      set_div(p == 0 ? 32'h100 : 32'h050);
      src_cycles(10);
      for (int k = 0; k < 8; k++) begin
        @(posedge clk_src); #1;
        if (clk_out !== 1'b1) bad++;
        @(negedge clk_src); #1;
        if (clk_out !== 1'b0) bad++;
      end
      check(p == 0 ? "R5 pass-through" : "R2 below 1.0 passes through", bad, 0);
    end

    // R6: divisor change mid-period
    set_div(32'h600);
    wait_rises(4);
    wait_rises(1);
    src_cycles(2);
    div_word = 32'hB00;
    wait_rises(1);
    check("R6 current period keeps old length", rise_cyc - rise_prev, 6);
    wait_rises(1);
    check("R6 next period uses new length", rise_cyc - rise_prev, 11);

    // R7: stop
    begin
      int n0;
      set_div(32'h800);
      wait_rises(4);
      wait_rises(1);
      src_cycles(3);
      enable = 1'b0;
      n0 = rise_cnt;
      src_cycles(60);
      check_range("R7 rises after disable", rise_cnt - n0, 1, 3);
      check("R7 last high phase full", fall_cyc - rise_cyc, 4);
      check("R7 output low", clk_out, 0);
      n0 = rise_cnt;
      src_cycles(40);
      check("R7 stays stopped", rise_cnt - n0, 0);
    end

    // R8: restart
    begin
      int en_cyc;
      @(negedge clk_src);
      enable = 1'b1;
      en_cyc = cyc;
      wait_rises(1);
      check_range("R8 restart latency", rise_cyc - en_cyc, 1, 2 + 3 * 8);
      wait_rises(1);
      check("R8 restart period full", rise_cyc - rise_prev, 8);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(150000 * 4);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule